// File: doc/BRIEF.md
# Timeslot-zero frame word sequencer

The block produces the 8-bit word carried in the synchronization timeslot of every frame on a primary-rate multiplex link. Frames are numbered 1 to 16 inside a multiframe. A frame strobe advances the frame number. A one-cycle pulse marks the start of each new multiframe.

Odd frames carry a fixed alignment pattern. Even frames carry a service word: a constant marker bit, the two alarm flags and four service bits taken straight from the inputs. The leading bit of every word, the X bit, comes from a 4-bit CRC result computed elsewhere. The block captures that nibble when its valid strobe is high. At each group of four frames it hands out the nibble one bit per frame, most significant bit first. The CRC itself, the serialization of the other timeslots and receive-side alignment are done elsewhere.

Top module: `ts0_word_seq`

## Requirements
- R1: While `rst_ni` is low, and after it rises until the first frame strobe: `frame_num_o` is 1, `mfs_o` is 0, and both the captured and the active CRC nibbles are 0000. In that state `word_o` reads 8'h1B.
- R2: In each cycle where `frame_i` is high at a rising clock edge, `frame_num_o` advances by one. From 16 it wraps to 1. The new value appears right after that edge. Without a strobe, `frame_num_o` holds.
- R3: `mfs_o` is high for exactly the one cycle after the strobe that wraps the frame number from 16 to 1. It is low at all other times.
- R4: In odd frames, `word_o[6:0]` is 7'b0011011.
- R5: In even frames, `word_o[6:0]` is {1, `alarm_d_i`, `alarm_n_i`, `svc_y_i[3:0]`}. These are the current input values, with no register in the path.
- R6: `word_o[7]` is the X bit. In frame f it equals bit (3 − ((f−1) mod 4)) of the active nibble. So frames 1, 5, 9 and 13 use bit 3, and frames 4, 8, 12 and 16 use bit 0.
- R7: A cycle with `crc_vld_i` high captures `crc_i`. The active nibble is updated only by the strobe that enters frame 1, 5, 9 or 13. It takes the captured value, or `crc_i` itself if `crc_vld_i` is high in that same cycle. A capture in the middle of a group changes no X bit of that group.
- R8: If several captures occur before a group boundary, the last one is the value that becomes active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | Frame strobe, one cycle per frame |
| alarm_d_i | input | 1 | Alarm flag D for even-frame words |
| alarm_n_i | input | 1 | Alarm flag N for even-frame words |
| svc_y_i | input | 4 | Service bits for even-frame words |
| crc_i | input | 4 | CRC nibble, bit 3 sent first |
| crc_vld_i | input | 1 | Capture strobe for `crc_i` |
| word_o | output | 8 | Timeslot word, bit 7 first on the line |
| frame_num_o | output | 5 | Current frame number, 1 to 16 |
| mfs_o | output | 1 | Multiframe start pulse |

## Verification
The bench loads a nibble in the middle of a group. A design that switched nibbles at once would show the new X bits in frames 2 to 4 instead of from frame 5. It drives a capture in the same cycle as a boundary strobe, which catches a design that takes the stale captured value. It also drives two captures before one boundary, which catches a design that keeps the first. It walks through the 16-to-1 wrap with idle cycles around it. An off-by-one counter would pulse `mfs_o` in the wrong frame, hold it for two cycles, or lose frame parity, and that last fault would swap the alignment and service formats.

// File: rtl/ts0_pkg.sv
package ts0_pkg;
  localparam int FRAMES = 16;
  localparam int CRC_W  = 4;
  localparam int WORD_W = 8;
  localparam int SVC_W  = 4;
  localparam logic [WORD_W-2:0] ALIGN_PAT = 7'b0011011;
endpackage

// File: rtl/ts0_frame_ctr.sv
module ts0_frame_ctr #(
  parameter int FRAMES_P = 16,
  parameter int GROUP_P  = 4,
  localparam int IW = $clog2(FRAMES_P),
  localparam int GB = $clog2(GROUP_P)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  output logic [IW-1:0] idx_o,
  output logic          grp_load_o,
  output logic          mfs_o
);
  localparam logic [IW-1:0] LAST = IW'(FRAMES_P - 1);

  logic [IW-1:0] idx_q, idx_nxt;
  logic          mfs_q;

  assign idx_nxt    = (idx_q == LAST) ? '0 : idx_q + 1'b1;
  // entering a frame whose index is a multiple of the group size
  assign grp_load_o = step_i && (idx_nxt[GB-1:0] == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      mfs_q <= 1'b0;
    end else begin
      if (step_i) idx_q <= idx_nxt;
      mfs_q <= step_i && (idx_q == LAST);
    end
  end

  assign idx_o = idx_q;
  assign mfs_o = mfs_q;

  a_r2_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && idx_q == LAST |=> idx_q == '0);
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(idx_q));
  a_r3_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mfs_q |=> !mfs_q);
  a_r3_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mfs_q |-> idx_q == '0);
endmodule

// File: rtl/ts0_crc_hold.sv
module ts0_crc_hold #(
  parameter int CRC_W_P = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               vld_i,
  input  logic [CRC_W_P-1:0] crc_i,
  input  logic               load_i,
  output logic [CRC_W_P-1:0] act_o
);
  logic [CRC_W_P-1:0] pend_q, act_q, pend_eff;

  // a capture in the boundary cycle bypasses the pending register
  assign pend_eff = vld_i ? crc_i : pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      pend_q <= pend_eff;
      if (load_i) act_q <= pend_eff;
    end
  end

  assign act_o = act_q;

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(act_q));
  a_r7_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && vld_i |=> act_q == $past(crc_i));
endmodule

// File: rtl/ts0_word_fmt.sv
module ts0_word_fmt
  import ts0_pkg::*;
#(
  parameter int FRAMES_P = 16,
  parameter int CRC_W_P  = 4,
  localparam int IW = $clog2(FRAMES_P),
  localparam int GB = $clog2(CRC_W_P)
) (
  input  logic [IW-1:0]      idx_i,
  input  logic [CRC_W_P-1:0] act_i,
  input  logic               d_i,
  input  logic               n_i,
  input  logic [SVC_W-1:0]   y_i,
  output logic [WORD_W-1:0]  word_o
);
  logic [GB-1:0] sel;
  logic          x_bit;

  // idx = frame - 1, so even idx is an odd frame
  assign sel   = GB'(CRC_W_P - 1) - idx_i[GB-1:0];
  assign x_bit = act_i[sel];

  always_comb begin
    if (!idx_i[0]) word_o = {x_bit, ALIGN_PAT};
    else           word_o = {x_bit, 1'b1, d_i, n_i, y_i};
  end
endmodule

// File: rtl/ts0_word_seq.sv
module ts0_word_seq
  import ts0_pkg::*;
#(
  parameter int FRAMES_P = FRAMES,
  parameter int CRC_W_P  = CRC_W,
  localparam int IW   = $clog2(FRAMES_P),
  localparam int FN_W = $clog2(FRAMES_P + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               frame_i,
  input  logic               alarm_d_i,
  input  logic               alarm_n_i,
  input  logic [SVC_W-1:0]   svc_y_i,
  input  logic [CRC_W_P-1:0] crc_i,
  input  logic               crc_vld_i,
  output logic [WORD_W-1:0]  word_o,
  output logic [FN_W-1:0]    frame_num_o,
  output logic               mfs_o
);
  logic [IW-1:0] idx;
  logic          grp_load;
  logic [CRC_W_P-1:0] act;

  ts0_frame_ctr #(.FRAMES_P(FRAMES_P), .GROUP_P(CRC_W_P)) u_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(frame_i),
    .idx_o(idx), .grp_load_o(grp_load), .mfs_o(mfs_o)
  );

  ts0_crc_hold #(.CRC_W_P(CRC_W_P)) u_crc (
    .clk_i(clk_i), .rst_ni(rst_ni), .vld_i(crc_vld_i), .crc_i(crc_i),
    .load_i(grp_load), .act_o(act)
  );

  ts0_word_fmt #(.FRAMES_P(FRAMES_P), .CRC_W_P(CRC_W_P)) u_fmt (
    .idx_i(idx), .act_i(act), .d_i(alarm_d_i), .n_i(alarm_n_i),
    .y_i(svc_y_i), .word_o(word_o)
  );

  assign frame_num_o = FN_W'(idx) + 1'b1;

  a_r4_marker: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_num_o[0] |-> word_o[6] == 1'b0);
  a_r5_marker: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_num_o[0] |-> word_o[6] == 1'b1);
  a_r5_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_num_o[0] |-> word_o[3:0] == svc_y_i);
  a_r3_frame_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mfs_o |-> frame_num_o == FN_W'(1));
endmodule

// File: tb/ts0_word_seq_test.sv
module ts0_word_seq_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       frame_i = 1'b0, alarm_d_i = 1'b0, alarm_n_i = 1'b0, crc_vld_i = 1'b0;
  logic [3:0] svc_y_i = '0, crc_i = '0;
  logic [7:0] word_o;
  logic [4:0] frame_num_o;
  logic       mfs_o;

  always #2 clk_i = ~clk_i;

  ts0_word_seq uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .frame_i(frame_i), .alarm_d_i(alarm_d_i),
    .alarm_n_i(alarm_n_i), .svc_y_i(svc_y_i), .crc_i(crc_i), .crc_vld_i(crc_vld_i),
    .word_o(word_o), .frame_num_o(frame_num_o), .mfs_o(mfs_o)
  );

  typedef struct {
    int         fnum;
    logic [7:0] word;
    logic       mfs;
    string      xtag;
  } exp_t;

  exp_t q[$];
  int n_chk = 0, n_bad = 0;
  bit done = 0;
  string cur_tag = "R6";

  int         m_idx = 0;
  logic [3:0] m_pend = '0, m_act = '0;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic s, input logic v, input logic [3:0] c,
                      input logic d, input logic n, input logic [3:0] y);
    exp_t e;
    int   nidx;
    logic x;
    @(negedge clk_i);
    frame_i = s; crc_vld_i = v; crc_i = c;
    alarm_d_i = d; alarm_n_i = n; svc_y_i = y;
    nidx = s ? ((m_idx == 15) ? 0 : m_idx + 1) : m_idx;
    if (s && (nidx % 4 == 0)) m_act = v ? c : m_pend;
    if (v) m_pend = c;
    e.mfs = s && (m_idx == 15);
    m_idx = nidx;
    x = m_act[3 - (m_idx % 4)];
    e.fnum = m_idx + 1;
    if (e.fnum % 2 == 1) e.word = {x, 7'b0011011};
    else                 e.word = {x, 1'b1, d, n, y};
    e.xtag = cur_tag;
    q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk_i);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        check("R2 frame", int'(frame_num_o), e.fnum);
        check("R3 mfs", int'(mfs_o), int'(e.mfs));
        if (e.fnum % 2 == 1) check("R4 odd word", int'(word_o[6:0]), int'(e.word[6:0]));
        else                 check("R5 even word", int'(word_o[6:0]), int'(e.word[6:0]));
        check({e.xtag, " X bit"}, int'(word_o[7]), int'(e.word[7]));
      end
    end
  end

  initial begin : watchdog
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk_i);
    // R1 during and after reset
    check("R1 frame in reset", int'(frame_num_o), 1);
    check("R1 word in reset", int'(word_o), 8'h1B);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 frame after reset", int'(frame_num_o), 1);
    check("R1 mfs after reset", int'(mfs_o), 0);
    check("R1 word after reset", int'(word_o), 8'h1B);

    // R7: mid-group capture, no strobe; frames 2..4 keep the zero nibble
    cur_tag = "R7";
    step(0, 1, 4'hB, 0, 0, 4'h0);
    for (int i = 0; i < 3; i++) step(1, 0, 4'h0, i[0], i[1], 4'(i + 5));
    // R6: frames 5..8 show 1,0,1,1
    cur_tag = "R6";
    for (int i = 0; i < 4; i++) step(1, 0, 4'h0, ~i[0], i[0], 4'(15 - i));
    // R7: capture in the boundary cycle entering frame 9
    cur_tag = "R7";
    step(1, 1, 4'h6, 1, 1, 4'hA);
    for (int i = 0; i < 3; i++) step(1, 0, 4'h0, 1, 0, 4'(i * 3));
    // R8: two captures before entering frame 13, the later one wins
    cur_tag = "R8";
    step(0, 1, 4'h3, 0, 1, 4'h5);
    step(0, 1, 4'hC, 0, 1, 4'h5);
    for (int i = 0; i < 4; i++) step(1, 0, 4'h0, i[1], ~i[1], 4'(i + 9));
    // R3: wrap into frame 1 with idle cycles around it
    cur_tag = "R6";
    step(1, 0, 4'h0, 0, 0, 4'h0);
    step(0, 0, 4'h0, 1, 1, 4'hF);
    step(0, 0, 4'h0, 1, 1, 4'hF);
    // second multiframe with gaps between strobes and new nibble 4'h9
    step(0, 1, 4'h9, 0, 0, 4'h0);
    for (int i = 0; i < 20; i++) begin
      step(1, 0, 4'h0, i[2], i[0], 4'(i * 7));
      if (i % 3 == 0) step(0, 0, 4'h0, i[1], i[2], 4'(i));
    end
    repeat (2) @(negedge clk_i);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule